// File: doc/BRIEF.md
# Platform Power-State Sequencer

This block steps a platform through its off, standby, suspend and running states (G3, S5, S3, S0). It watches the power-good signals of the supply rails and the sleep-level lines coming from the chipset. In response it drives the rail enables, the chipset well and resume lines, peripheral resets and a CPU throttle line. Every settle delay and every rail-wait timeout is a parameter in microseconds or nanoseconds, turned into clock cycles from the clock frequency. A supply that does not come up within its timeout makes the block force a shutdown and roll back to the previous stable state.

Every control and status pin is a plain level. There is no data stream, so the block has no valid/ready interface and no back-pressure. The rail vector is indexed as follows: bit 0 is the always-on supply, bit 1 is the memory supply, and the remaining bits are the other non-core rails. The state code shows the current step: 0 G3, 1 S5, 2 S3, 3 S0, 4 well-power delay, 5 suspend-clock delay, 6 always-on wait, 7 memory-rail wait, 8 non-core rail wait, 9 core settle delay, 10 shutdown gap.

Top module: `plat_pwr_seq`

## Requirements
- R1: While reset is asserted and right after it is released, every output except `warn_ack_n` is 0, and `state_code` is 0 (G3).
- R2: The block stays in G3 (code 0) while `power_on_req` is low. In S5 (code 1), a low `power_on_req` returns the block to G3 at the next clock edge and drives `dswell_ok` and `resume_rst_n` low.
- R3: A high `power_on_req` in G3 enters code 4 for exactly DSW cycles. At the end of that delay, `dswell_ok` and `resume_rst_n` go high and code 5 is held for exactly SUSCLK cycles. The block then enters S5 (code 1).
- R4: In S5 with `chip_sleep5_n` high, the block passes through code 6 and waits for rail bit 0. It then releases `lbar_rst_n` and sets `ddr_en`, and passes through code 7 to wait for rail bits 0 and 1. Once those are good it sets `tpad_en` and enters S3 (code 2).
- R5: If the wait in code 6 or code 7 lasts TMO cycles without the rails it needs, the block returns to S5 with `dswell_ok` and `resume_rst_n` low.
- R6: While the block stays in S3, `tscrn_rst_n` equals `lid_open` one cycle later.
- R7: In S3, the loss of rail bit 0 or bit 1 forces a shutdown and moves to S5. A low `chip_sleep5_n` also moves to S5. Either move clears `tpad_en`, `ddr_en`, `tscrn_rst_n` and `lbar_rst_n`. A high `chip_sleep3_n` instead moves to code 8.
- R8: Entering code 8 sets `vs_en` and `tscrn_rst_n`. If not all rails are good within TMO cycles, the block forces a shutdown, clears `tscrn_rst_n` and `vs_en`, and returns to S3.
- R9: When all rails are good in code 8, `core_en` goes high and code 9 is held for exactly CORE cycles. The block then enters S0 (code 3) with `chipset_pwr_ok` high and `cpu_throttle` equal to `throttle_req`.
- R10: In S0, a low `chip_sleep3_n` or the loss of any rail moves to code 10 and drops `chipset_pwr_ok`; the rail loss also forces a shutdown. After GAP cycles (at least 40 ns), `core_en`, `vs_en` and `cpu_throttle` go low and the block enters S3.
- R11: A high `force_off` drives `dswell_ok` and `resume_rst_n` low at the next clock edge in any state, and does not change the state.
- R12: In S0, `cpu_throttle` follows `throttle_req` one cycle later. Outside S0 it does not follow the request, and the request is applied on the next entry to S0.
- R13: `warn_ack_n` always equals `warn_in_n`, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rail_good | input | NUM_RAILS | Rail power-good bits (0 always-on, 1 memory, others non-core) |
| chip_sleep3_n | input | 1 | Chipset suspend-level sleep line, high = awake |
| chip_sleep5_n | input | 1 | Chipset soft-off sleep line, high = awake |
| lid_open | input | 1 | Lid open indication |
| throttle_req | input | 1 | CPU throttle request level |
| force_off | input | 1 | Forced shutdown request |
| power_on_req | input | 1 | Permission to leave G3 |
| warn_in_n | input | 1 | Suspend-well warning from chipset |
| dswell_ok | output | 1 | Deep-sleep well power good to chipset |
| resume_rst_n | output | 1 | Chipset resume-well reset, low = in reset |
| ddr_en | output | 1 | Memory supply enable |
| vs_en | output | 1 | Switched non-core supply enable |
| core_en | output | 1 | CPU and graphics core supply enable |
| tpad_en | output | 1 | Touchpad power enable |
| tscrn_rst_n | output | 1 | Touchscreen reset, low = in reset |
| lbar_rst_n | output | 1 | Light-bar reset, low = in reset |
| cpu_throttle | output | 1 | CPU hot / throttle line |
| chipset_pwr_ok | output | 1 | Main power good to chipset |
| warn_ack_n | output | 1 | Acknowledge of the suspend-well warning |
| state_code | output | 4 | Current step code |

## Verification
Assertions check the following on every cycle:
- `chipset_pwr_ok` is high only in S0, and `core_en` is never high without `vs_en`.
- The G3 hold, the force-off response and the rollback of code 8 hold.
- In S3, `tscrn_rst_n` follows the lid, and in S0, `cpu_throttle` follows the request.
- The memory enable and light-bar release stay in place during the memory wait.

Only the bench scenarios can show the following:
- The exact dwell of each delay and timeout.
- The full ordered sequence of output changes along the up and down paths.
- That a throttle request made outside S0 is applied when S0 is next entered.
- That a rail loss in S3 leads to the S5 teardown.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [3:0] {
    ST_G3     = 4'd0,
    ST_S5     = 4'd1,
    ST_S3     = 4'd2,
    ST_S0     = 4'd3,
    ST_DSW    = 4'd4,
    ST_SUSCLK = 4'd5,
    ST_AON    = 4'd6,
    ST_MEM    = 4'd7,
    ST_RAILS  = 4'd8,
    ST_CORE   = 4'd9,
    ST_GAP    = 4'd10
  } pwr_st_e;

  // microseconds to clock cycles, at least one cycle
  function automatic longint us_cycles(longint khz, longint us);
    longint c;
    c = (khz * us) / 64'sd1000;
    if (c < 1) c = 1;
    return c;
  endfunction

  // nanoseconds to clock cycles, rounded up, at least one cycle
  function automatic longint ns_cycles(longint khz, longint ns);
    longint c;
    c = (khz * ns + 64'sd999999) / 64'sd1000000;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);

  // cycles spent in the current step, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (cnt != '1)  cnt <= cnt + 1'b1;
  end

  p_clr_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

endmodule

// File: rtl/pwrseq_railmon.sv
module pwrseq_railmon #(
  parameter int NUM_RAILS = 6
) (
  input  logic [NUM_RAILS-1:0] rail_good,
  output logic                 aon_ok,
  output logic                 s3_ok,
  output logic                 s0_ok
);

  localparam int NGRP = 3;
  localparam logic [NUM_RAILS-1:0] AON_MASK = NUM_RAILS'(1);
  localparam logic [NUM_RAILS-1:0] S3_MASK  = NUM_RAILS'(3);
  localparam logic [NUM_RAILS-1:0] S0_MASK  = '1;

  logic [NGRP-1:0] grp_ok;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam logic [NUM_RAILS-1:0] M =
      (g == 0) ? AON_MASK : ((g == 1) ? S3_MASK : S0_MASK);
    assign grp_ok[g] = &(rail_good | ~M);
  end

  assign aon_ok = grp_ok[0];
  assign s3_ok  = grp_ok[1];
  assign s0_ok  = grp_ok[2];

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int DSW_LEN    = 10,
  parameter int SUSCLK_LEN = 5,
  parameter int CORE_LEN   = 20,
  parameter int GAP_LEN    = 2,
  parameter int TMO_LEN    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  output logic             tmr_clr,
  input  logic             aon_ok,
  input  logic             s3_ok,
  input  logic             s0_ok,
  input  logic             chip_sleep3_n,
  input  logic             chip_sleep5_n,
  input  logic             lid_open,
  input  logic             throttle_req,
  input  logic             force_off,
  input  logic             power_on_req,
  output logic             dswell_ok,
  output logic             resume_rst_n,
  output logic             ddr_en,
  output logic             vs_en,
  output logic             core_en,
  output logic             tpad_en,
  output logic             tscrn_rst_n,
  output logic             lbar_rst_n,
  output logic             cpu_throttle,
  output logic             chipset_pwr_ok,
  output logic [3:0]       state_code
);

  localparam logic [CNT_W-1:0] DSW_LAST    = CNT_W'(DSW_LEN - 1);
  localparam logic [CNT_W-1:0] SUSCLK_LAST = CNT_W'(SUSCLK_LEN - 1);
  localparam logic [CNT_W-1:0] CORE_LAST   = CNT_W'(CORE_LEN - 1);
  localparam logic [CNT_W-1:0] GAP_LAST    = CNT_W'(GAP_LEN - 1);
  localparam logic [CNT_W-1:0] TMO_LAST    = CNT_W'(TMO_LEN - 1);

  pwr_st_e st_q, st_d;
  logic    rail_fail;

  // next step and rail-failure decision
  always_comb begin
    st_d      = st_q;
    rail_fail = 1'b0;
    unique case (st_q)
      ST_G3:     if (power_on_req) st_d = ST_DSW;
      ST_DSW:    if (cnt == DSW_LAST) st_d = ST_SUSCLK;
      ST_SUSCLK: if (cnt == SUSCLK_LAST) st_d = ST_S5;
      ST_S5: begin
        if (!power_on_req)      st_d = ST_G3;
        else if (chip_sleep5_n) st_d = ST_AON;
      end
      ST_AON: begin
        if (aon_ok) st_d = ST_MEM;
        else if (cnt == TMO_LAST) begin
          st_d = ST_S5; rail_fail = 1'b1;
        end
      end
      ST_MEM: begin
        if (s3_ok) st_d = ST_S3;
        else if (cnt == TMO_LAST) begin
          st_d = ST_S5; rail_fail = 1'b1;
        end
      end
      ST_S3: begin
        if (!s3_ok) begin
          st_d = ST_S5; rail_fail = 1'b1;
        end
        else if (chip_sleep3_n)  st_d = ST_RAILS;
        else if (!chip_sleep5_n) st_d = ST_S5;
      end
      ST_RAILS: begin
        if (s0_ok) st_d = ST_CORE;
        else if (cnt == TMO_LAST) begin
          st_d = ST_S3; rail_fail = 1'b1;
        end
      end
      ST_CORE: if (cnt == CORE_LAST) st_d = ST_S0;
      ST_S0: begin
        if (!s0_ok) begin
          st_d = ST_GAP; rail_fail = 1'b1;
        end
        else if (!chip_sleep3_n) st_d = ST_GAP;
      end
      ST_GAP:  if (cnt == GAP_LAST) st_d = ST_S3;
      default: st_d = ST_G3;
    endcase
  end

  assign tmr_clr    = (st_d != st_q);
  assign state_code = st_q;

  // output actions tied to each step change
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q           <= ST_G3;
      dswell_ok      <= 1'b0;
      resume_rst_n   <= 1'b0;
      ddr_en         <= 1'b0;
      vs_en          <= 1'b0;
      core_en        <= 1'b0;
      tpad_en        <= 1'b0;
      tscrn_rst_n    <= 1'b0;
      lbar_rst_n     <= 1'b0;
      cpu_throttle   <= 1'b0;
      chipset_pwr_ok <= 1'b0;
    end else begin
      st_q <= st_d;
      unique case (st_q)
        ST_DSW: if (st_d == ST_SUSCLK) begin
          dswell_ok    <= 1'b1;
          resume_rst_n <= 1'b1;
        end
        ST_S5: if (st_d == ST_G3) begin
          dswell_ok    <= 1'b0;
          resume_rst_n <= 1'b0;
        end
        ST_AON: if (st_d == ST_MEM) begin
          lbar_rst_n <= 1'b1;
          ddr_en     <= 1'b1;
        end
        ST_MEM: if (st_d == ST_S3) tpad_en <= 1'b1;
        ST_S3: begin
          if (st_d == ST_S3) tscrn_rst_n <= lid_open;
          else if (st_d == ST_RAILS) begin
            vs_en       <= 1'b1;
            tscrn_rst_n <= 1'b1;
          end else begin
            tpad_en     <= 1'b0;
            ddr_en      <= 1'b0;
            tscrn_rst_n <= 1'b0;
            lbar_rst_n  <= 1'b0;
          end
        end
        ST_RAILS: begin
          if (st_d == ST_CORE) core_en <= 1'b1;
          else if (st_d == ST_S3) begin
            tscrn_rst_n <= 1'b0;
            vs_en       <= 1'b0;
          end
        end
        ST_CORE: if (st_d == ST_S0) begin
          chipset_pwr_ok <= 1'b1;
          cpu_throttle   <= throttle_req;
        end
        ST_S0: begin
          if (st_d == ST_S0) cpu_throttle   <= throttle_req;
          else               chipset_pwr_ok <= 1'b0;
        end
        ST_GAP: if (st_d == ST_S3) begin
          core_en      <= 1'b0;
          cpu_throttle <= 1'b0;
          vs_en        <= 1'b0;
        end
        default: ;
      endcase
      if (rail_fail || force_off) begin
        dswell_ok    <= 1'b0;
        resume_rst_n <= 1'b0;
      end
    end
  end

  p_g3_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_G3 && !power_on_req) |=> (st_q == ST_G3));

  p_mem_wait_rails_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_MEM) |-> (ddr_en && lbar_rst_n));

  p_lid_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_S3 && st_d == ST_S3) |=> (tscrn_rst_n == $past(lid_open)));

  p_rollback_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RAILS && st_d == ST_S3) |=> (!vs_en && !tscrn_rst_n && !dswell_ok));

  p_pwrok_s0_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chipset_pwr_ok |-> (st_q == ST_S0));

  p_core_needs_vs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    core_en |-> vs_en);

  p_force_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |=> (!dswell_ok && !resume_rst_n && st_q == $past(st_d)));

  p_throttle_s0_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_S0 && st_d == ST_S0) |=> (cpu_throttle == $past(throttle_req)));

endmodule

// File: rtl/plat_pwr_seq.sv
module plat_pwr_seq #(
  parameter int NUM_RAILS   = 6,
  parameter int CLK_KHZ     = 50000,
  parameter int DSW_US      = 10000,
  parameter int SUSCLK_US   = 5000,
  parameter int CORE_US     = 99000,
  parameter int GAP_NS      = 40,
  parameter int RAIL_TMO_US = 2000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RAILS-1:0] rail_good,
  input  logic                 chip_sleep3_n,
  input  logic                 chip_sleep5_n,
  input  logic                 lid_open,
  input  logic                 throttle_req,
  input  logic                 force_off,
  input  logic                 power_on_req,
  input  logic                 warn_in_n,
  output logic                 dswell_ok,
  output logic                 resume_rst_n,
  output logic                 ddr_en,
  output logic                 vs_en,
  output logic                 core_en,
  output logic                 tpad_en,
  output logic                 tscrn_rst_n,
  output logic                 lbar_rst_n,
  output logic                 cpu_throttle,
  output logic                 chipset_pwr_ok,
  output logic                 warn_ack_n,
  output logic [3:0]           state_code
);

  localparam longint DSW_C    = pwrseq_pkg::us_cycles(CLK_KHZ, DSW_US);
  localparam longint SUSCLK_C = pwrseq_pkg::us_cycles(CLK_KHZ, SUSCLK_US);
  localparam longint CORE_C   = pwrseq_pkg::us_cycles(CLK_KHZ, CORE_US);
  localparam longint GAP_C    = pwrseq_pkg::ns_cycles(CLK_KHZ, GAP_NS);
  localparam longint TMO_C    = pwrseq_pkg::us_cycles(CLK_KHZ, RAIL_TMO_US);
  localparam longint MAX_A    = (DSW_C > SUSCLK_C) ? DSW_C : SUSCLK_C;
  localparam longint MAX_B    = (CORE_C > TMO_C) ? CORE_C : TMO_C;
  localparam longint MAX_C    = (MAX_A > MAX_B) ? ((MAX_A > GAP_C) ? MAX_A : GAP_C)
                                                : ((MAX_B > GAP_C) ? MAX_B : GAP_C);
  localparam int     CNT_W    = $clog2(MAX_C + 1);

  logic [CNT_W-1:0] cnt;
  logic             tmr_clr;
  logic             aon_ok, s3_ok, s0_ok;

  // warning acknowledge is a plain pass-through
  assign warn_ack_n = warn_in_n;

  pwrseq_railmon #(.NUM_RAILS(NUM_RAILS)) u_railmon (
    .rail_good (rail_good),
    .aon_ok    (aon_ok),
    .s3_ok     (s3_ok),
    .s0_ok     (s0_ok)
  );

  pwrseq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .cnt   (cnt)
  );

  pwrseq_fsm #(
    .CNT_W      (CNT_W),
    .DSW_LEN    (int'(DSW_C)),
    .SUSCLK_LEN (int'(SUSCLK_C)),
    .CORE_LEN   (int'(CORE_C)),
    .GAP_LEN    (int'(GAP_C)),
    .TMO_LEN    (int'(TMO_C))
  ) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .cnt            (cnt),
    .tmr_clr        (tmr_clr),
    .aon_ok         (aon_ok),
    .s3_ok          (s3_ok),
    .s0_ok          (s0_ok),
    .chip_sleep3_n  (chip_sleep3_n),
    .chip_sleep5_n  (chip_sleep5_n),
    .lid_open       (lid_open),
    .throttle_req   (throttle_req),
    .force_off      (force_off),
    .power_on_req   (power_on_req),
    .dswell_ok      (dswell_ok),
    .resume_rst_n   (resume_rst_n),
    .ddr_en         (ddr_en),
    .vs_en          (vs_en),
    .core_en        (core_en),
    .tpad_en        (tpad_en),
    .tscrn_rst_n    (tscrn_rst_n),
    .lbar_rst_n     (lbar_rst_n),
    .cpu_throttle   (cpu_throttle),
    .chipset_pwr_ok (chipset_pwr_ok),
    .state_code     (state_code)
  );

  p_warn_mirror_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(warn_in_n) |-> (warn_ack_n == $past(warn_in_n)));

endmodule

// File: tb/plat_pwr_seq_bench.sv
module plat_pwr_seq_bench;

  localparam int NR = 6;
  // 50 MHz with short delays: DSW 100, SUSCLK 50, CORE 150, GAP 2, TMO 50 cycles
  localparam int E_DSW = 100, E_SUS = 50, E_CORE = 150, E_GAP = 2, E_TMO = 50;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NR-1:0] rail_good = '0;
  logic chip_sleep3_n = 0, chip_sleep5_n = 0, lid_open = 0, throttle_req = 0;
  logic force_off = 0, power_on_req = 0, warn_in_n = 1;
  logic dswell_ok, resume_rst_n, ddr_en, vs_en, core_en, tpad_en;
  logic tscrn_rst_n, lbar_rst_n, cpu_throttle, chipset_pwr_ok, warn_ack_n;
  logic [3:0] state_code;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  plat_pwr_seq #(.NUM_RAILS(NR), .CLK_KHZ(50000), .DSW_US(2), .SUSCLK_US(1),
                 .CORE_US(3), .GAP_NS(40), .RAIL_TMO_US(1)) u_plat_pwr_seq (
    .clk(clk), .rst_n(rst_n), .rail_good(rail_good),
    .chip_sleep3_n(chip_sleep3_n), .chip_sleep5_n(chip_sleep5_n),
    .lid_open(lid_open), .throttle_req(throttle_req), .force_off(force_off),
    .power_on_req(power_on_req), .warn_in_n(warn_in_n),
    .dswell_ok(dswell_ok), .resume_rst_n(resume_rst_n), .ddr_en(ddr_en),
    .vs_en(vs_en), .core_en(core_en), .tpad_en(tpad_en),
    .tscrn_rst_n(tscrn_rst_n), .lbar_rst_n(lbar_rst_n),
    .cpu_throttle(cpu_throttle), .chipset_pwr_ok(chipset_pwr_ok),
    .warn_ack_n(warn_ack_n), .state_code(state_code));

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // advance at negedges until the state code matches
  task automatic wait_for(int code, string req);
    int k = 0;
    while (int'(state_code) != code && k < 5000) begin
      @(negedge clk); k++;
    end
    chk(req, "reach code", int'(state_code), code);
  endtask

  // count consecutive negedges (this one included) holding the code
  task automatic dwell(int code, output int n);
    n = 0;
    while (int'(state_code) == code && n < 100000) begin
      n++; @(negedge clk);
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1", "code in reset", int'(state_code), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "outputs after reset", int'({dswell_ok, resume_rst_n, ddr_en, vs_en,
        core_en, tpad_en, tscrn_rst_n, lbar_rst_n, cpu_throttle, chipset_pwr_ok}), 0);
    chk("R1", "code after reset", int'(state_code), 0);
  endtask

  task automatic t_g3_hold;
    repeat (20) @(negedge clk);
    chk("R2", "G3 without request", int'(state_code), 0);
  endtask

  task automatic t_power_up(bit timed);
    int n;
    power_on_req = 1'b1;
    @(negedge clk);
    chk("R3", "delay step", int'(state_code), 4);
    dwell(4, n);
    if (timed) chk("R3", "well delay cycles", n, E_DSW);
    chk("R3", "well ok after delay", int'({dswell_ok, resume_rst_n}), 3);
    dwell(5, n);
    if (timed) chk("R3", "susclk delay cycles", n, E_SUS);
    chk("R3", "in S5", int'(state_code), 1);
  endtask

  task automatic t_s5_to_s3;
    rail_good = '1;
    chip_sleep5_n = 1'b1;
    @(negedge clk);
    chk("R4", "always-on wait", int'(state_code), 6);
    @(negedge clk);
    chk("R4", "memory wait", int'(state_code), 7);
    chk("R4", "ddr and lightbar", int'({ddr_en, lbar_rst_n, tpad_en}), 6);
    @(negedge clk);
    chk("R4", "in S3", int'(state_code), 2);
    chk("R4", "touchpad on", int'(tpad_en), 1);
  endtask

  task automatic t_lid;
    lid_open = 1'b1;
    @(negedge clk);
    chk("R6", "lid open", int'(tscrn_rst_n), 1);
    lid_open = 1'b0;
    @(negedge clk);
    chk("R6", "lid closed", int'(tscrn_rst_n), 0);
  endtask

  task automatic t_s3_to_s0(bit exp_thr);
    int n;
    chip_sleep3_n = 1'b1;
    @(negedge clk);
    chk("R7", "to rail wait", int'(state_code), 8);
    chk("R8", "vs and tscrn on", int'({vs_en, tscrn_rst_n}), 3);
    @(negedge clk);
    chk("R9", "core settle", int'(state_code), 9);
    chk("R9", "core on, pwrok off", int'({core_en, chipset_pwr_ok}), 2);
    dwell(9, n);
    chk("R9", "core delay cycles", n, E_CORE);
    chk("R9", "in S0", int'(state_code), 3);
    chk("R9", "pwrok", int'(chipset_pwr_ok), 1);
    chk("R12", "throttle at S0 entry", int'(cpu_throttle), int'(exp_thr));
  endtask

  task automatic t_throttle_s0;
    throttle_req = 1'b0;
    @(negedge clk);
    chk("R12", "S0 throttle off", int'(cpu_throttle), 0);
    throttle_req = 1'b1;
    @(negedge clk);
    chk("R12", "S0 throttle on", int'(cpu_throttle), 1);
  endtask

  task automatic t_s0_down;
    int n;
    chip_sleep3_n = 1'b0;
    @(negedge clk);
    chk("R10", "gap step", int'(state_code), 10);
    chk("R10", "pwrok first, core still on", int'({chipset_pwr_ok, core_en}), 1);
    dwell(10, n);
    chk("R10", "gap cycles", n, E_GAP);
    chk("R10", "back in S3", int'(state_code), 2);
    chk("R10", "core vs throttle off", int'({core_en, vs_en, cpu_throttle}), 0);
  endtask

  task automatic t_throttle_held;
    throttle_req = 1'b1;
    repeat (5) @(negedge clk);
    chk("R12", "held off in S3", int'(cpu_throttle), 0);
  endtask

  task automatic t_force;
    lid_open = 1'b1;
    force_off = 1'b1;
    @(negedge clk);
    force_off = 1'b0;
    chk("R11", "well lines low", int'({dswell_ok, resume_rst_n}), 0);
    chk("R11", "state kept", int'(state_code), 2);
    @(negedge clk);
  endtask

  task automatic t_s3_teardown;
    chk("R6", "tscrn high before teardown", int'(tscrn_rst_n), 1);
    chip_sleep5_n = 1'b0;
    @(negedge clk);
    chk("R7", "to S5", int'(state_code), 1);
    chk("R7", "teardown outputs", int'({tpad_en, ddr_en, tscrn_rst_n, lbar_rst_n}), 0);
  endtask

  task automatic t_to_g3;
    power_on_req = 1'b0;
    @(negedge clk);
    chk("R2", "S5 to G3", int'(state_code), 0);
    chk("R2", "well lines low", int'({dswell_ok, resume_rst_n}), 0);
  endtask

  task automatic t_aon_timeout;
    int n;
    rail_good = '0;
    chip_sleep5_n = 1'b1;
    @(negedge clk);
    chk("R5", "always-on wait", int'(state_code), 6);
    dwell(6, n);
    chip_sleep5_n = 1'b0;
    chk("R5", "timeout cycles", n, E_TMO);
    chk("R5", "back to S5", int'(state_code), 1);
    chk("R5", "forced shutdown", int'({dswell_ok, resume_rst_n}), 0);
  endtask

  task automatic t_rail_rollback;
    int n;
    rail_good = 6'b011111;
    lid_open = 1'b1;
    chip_sleep3_n = 1'b1;
    @(negedge clk);
    chk("R8", "rail wait", int'(state_code), 8);
    dwell(8, n);
    chip_sleep3_n = 1'b0;
    chk("R8", "timeout cycles", n, E_TMO);
    chk("R8", "back in S3", int'(state_code), 2);
    chk("R8", "vs off, tscrn reset, shutdown",
        int'({vs_en, tscrn_rst_n, dswell_ok, core_en}), 0);
    @(negedge clk);
    chk("R6", "lid followed again", int'(tscrn_rst_n), 1);
  endtask

  task automatic t_s3_rail_loss;
    rail_good = 6'b111101;
    @(negedge clk);
    chk("R7", "rail loss to S5", int'(state_code), 1);
    chk("R7", "ddr and touchpad off", int'({ddr_en, tpad_en}), 0);
  endtask

  task automatic t_warn;
    warn_in_n = 1'b0;
    #1;
    chk("R13", "ack low", int'(warn_ack_n), 0);
    warn_in_n = 1'b1;
    #1;
    chk("R13", "ack high", int'(warn_ack_n), 1);
  endtask

  initial begin
    t_reset();
    t_g3_hold();
    t_power_up(1'b1);
    t_s5_to_s3();
    t_lid();
    throttle_req = 1'b1;
    t_s3_to_s0(1'b1);
    t_throttle_s0();
    t_s0_down();
    t_throttle_held();
    t_s3_to_s0(1'b1);
    throttle_req = 1'b0;
    t_s0_down();
    t_force();
    t_s3_teardown();
    t_to_g3();
    t_power_up(1'b0);
    t_aon_timeout();
    t_to_g3();
    t_power_up(1'b0);
    t_s5_to_s3();
    t_rail_rollback();
    t_s3_rail_loss();
    t_warn();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule